// File: doc/BRIEF.md
# CRC32C Length Constant Generator

This unit produces the 32-bit multiplier constant that advances a partial CRC32C value past a segment of known byte length, so that separately computed segment CRCs can later be merged. It works in the bit-reflected domain of the CRC32C polynomial. The constant is x raised to a power that depends on the segment length, reduced modulo the polynomial. The exponent is 8*(n-8) for n bytes, because the later fold step already accounts for 8 bytes.

A request is a one-cycle `start` with the byte count on `seg_len`. The unit loads a remainder register and a step counter. It then applies the reduction `BITS_PER_CYCLE` bit steps per clock and pulses `done` when the constant is ready on `span_const`. The constant stays on the output until a later request replaces it. Lengths below 16 bytes give a zero constant at once, with no stepping.

Top module: `crc32c_span_const`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `span_const` is 0x00000000.
- R2: For n >= 16, the result equals a 32-bit remainder that starts at 0x00000001 and is then stepped 8*(n-8) times. Each step shifts the remainder right by one bit and, if the bit shifted out was 1, XORs in 0x82F63B78.
- R3: For n = 4096 the result is 0x82F89C77.
- R4: For n < 16 (including 0), `span_const` becomes 0 and `done` pulses in the cycle right after the accepted start, and `busy` is never raised.
- R5: For n >= 16, `busy` is high from the cycle after the accepted start for exactly 8*(n-8)/BITS_PER_CYCLE cycles. `done` rises in the cycle where `busy` falls, and `done` is never high together with `busy`.
- R6: `done` is high for one cycle only. `span_const` keeps its value while busy and while idle, until a later accepted start replaces it.
- R7: A `start` that arrives while `busy` is high is ignored: it changes neither the result nor the completion time of the run in progress.
- R8: With BITS_PER_CYCLE set to 1, 2, 4 or 8, the result is the same for any length. Only the number of busy cycles changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; accepted when not busy |
| seg_len | input | LEN_W (16) | Segment length in bytes, sampled with an accepted start |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle pulse when a new constant is on the output |
| span_const | output | 32 | Reflected length constant |

## Verification
The assertions assume that `start` is a synchronous level sampled on each rising edge. They also assume that `seg_len` matters only in a cycle where a start is accepted, so length changes while busy or idle must not affect the outputs. The stimulus changes `seg_len` only together with `start`, except in the deliberate test of a start issued while busy. That test offers a different length in mid-run and expects the first run to finish unchanged. Two instances, one stepping one bit per clock and one stepping eight, run on the same stimulus. Their results are compared with a model computed in the bench and with the fixed value for 4096 bytes.

// File: rtl/crc32c_span_const.sv
module crc32c_span_const #(
  parameter int          LEN_W          = 16,
  parameter int          BITS_PER_CYCLE = 8,
  parameter logic [31:0] POLY           = 32'h82F63B78,
  parameter int          MIN_LEN        = 16,
  parameter int          FOLD_BYTES     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] seg_len,
  output logic             busy,
  output logic             done,
  output logic [31:0]      span_const
);
  localparam int CNT_W   = 32;
  localparam int STEP_SH = $clog2(BITS_PER_CYCLE);

  logic [31:0]      rem_q, rem_nxt, res_q;
  logic [CNT_W-1:0] left_q, load_cnt;
  logic             busy_q, done_q;
  logic             accept, short_len, last;

  assign accept    = start && !busy_q;
  assign short_len = seg_len < LEN_W'(MIN_LEN);
  assign load_cnt  = ((CNT_W'(seg_len) - CNT_W'(FOLD_BYTES)) << 3) >> STEP_SH;
  assign last      = busy_q && (left_q == CNT_W'(1));

  always_comb begin
    rem_nxt = rem_q;
    for (int i = 0; i < BITS_PER_CYCLE; i++)
      rem_nxt = rem_nxt[0] ? ((rem_nxt >> 1) ^ POLY) : (rem_nxt >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      left_q <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (short_len) begin
          res_q  <= '0;
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          rem_q  <= 32'd1;
          left_q <= load_cnt;
        end
      end else if (busy_q) begin
        rem_q  <= rem_nxt;
        left_q <= left_q - CNT_W'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= rem_nxt;
        end
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign span_const = res_q;
endmodule

// File: rtl/crc32c_span_const_chk.sv
module crc32c_span_const_chk #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] seg_len,
  input logic             busy,
  input logic             done,
  input logic [31:0]      span_const
);
  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && seg_len >= LEN_W'(MIN_LEN)) |=> busy);

  // R4
  short_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && seg_len < LEN_W'(MIN_LEN)) |=> (done && !busy && span_const == 32'd0));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(span_const));

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(span_const));
endmodule

bind crc32c_span_const crc32c_span_const_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .seg_len(seg_len),
  .busy(busy), .done(done), .span_const(span_const)
);

// File: tb/crc32c_span_const_tb.sv
module crc32c_span_const_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] seg_len = '0;
  logic        busy8, done8, busy1, done1;
  logic [31:0] out8, out1;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  crc32c_span_const #(.BITS_PER_CYCLE(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seg_len(seg_len),
    .busy(busy8), .done(done8), .span_const(out8));

  crc32c_span_const #(.BITS_PER_CYCLE(1)) u_dut_b1 (
    .clk(clk), .rst_n(rst_n), .start(start), .seg_len(seg_len),
    .busy(busy1), .done(done1), .span_const(out1));

  function automatic logic [31:0] ref_const(int n);
    logic [31:0] r;
    if (n < 16) return 32'd0;
    r = 32'd1;
    for (int i = 0; i < 8 * (n - 8); i++)
      r = r[0] ? ((r >> 1) ^ 32'h82F63B78) : (r >> 1);
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    check(busy8 == 0 && busy1 == 0, "R1", "busy after reset", {busy8, busy1}, 0);
    check(done8 == 0 && done1 == 0, "R1", "done after reset", {done8, done1}, 0);
    check(out8 == 0, "R1", "const after reset", out8, 0);
    check(out1 == 0, "R1", "const after reset (1b)", out1, 0);
  endtask

  task automatic run_len(int n, string req, int inject_at = -1, int alt = 0);
    int c8 = 0, c1 = 0, guard = 0;
    bit d8 = 0, d1 = 0;
    logic [31:0] r8 = '0, r1 = '0, exp;
    int e8, e1;
    exp = ref_const(n);
    e8 = (n < 16) ? 0 : (n - 8);
    e1 = (n < 16) ? 0 : 8 * (n - 8);
    @(negedge clk);
    seg_len = 16'(n);
    start = 1'b1;
    @(posedge clk);
    while (!(d8 && d1) && guard < 40000) begin
      @(negedge clk);
      start = 1'b0;
      if (guard == inject_at) begin
        seg_len = 16'(alt);
        start = 1'b1;
      end
      if (!d8) begin
        if (done8) begin d8 = 1; r8 = out8; check(!busy8, req, "busy with done (8b)", busy8, 0); end
        else c8++;
      end
      if (!d1) begin
        if (done1) begin d1 = 1; r1 = out1; check(!busy1, req, "busy with done (1b)", busy1, 0); end
        else c1++;
      end
      guard++;
    end
    start = 1'b0;
    check(d8 && d1, req, "completion seen", {d8, d1}, 3);
    check(r8 == exp, req, $sformatf("const n=%0d (8b)", n), r8, exp);
    check(r1 == exp, "R8", $sformatf("const n=%0d (1b)", n), r1, exp);
    check(c8 == e8, req, $sformatf("busy cycles n=%0d (8b)", n), c8, e8);
    check(c1 == e1, "R8", $sformatf("busy cycles n=%0d (1b)", n), c1, e1);
    @(negedge clk);
    check(!done8 && !done1, "R6", "done single cycle", {done8, done1}, 0);
  endtask

  task automatic test_hold(int n);
    logic [31:0] exp;
    exp = ref_const(n);
    seg_len = 16'd3000;
    repeat (10) @(negedge clk);
    check(out8 == exp, "R6", "const held idle (8b)", out8, exp);
    check(out1 == exp, "R6", "const held idle (1b)", out1, exp);
    check(!busy8 && !busy1, "R6", "idle stays idle", {busy8, busy1}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_len(16, "R2");
    test_hold(16);
    run_len(17, "R2");
    run_len(15, "R4");
    run_len(0, "R4");
    run_len(100, "R2");
    run_len(100, "R7", 5, 20);
    test_hold(100);
    run_len(1024, "R2");
    run_len(4095, "R2");
    run_len(4096, "R3");
    check(out8 == 32'h82F89C77, "R3", "fixed value 4096", out8, 32'h82F89C77);
    run_len(15, "R4");
    check(out8 == 0, "R4", "short clears previous", out8, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule